// File: doc/BRIEF.md
# Paged Register Access Controller

This block sits between an 8-bit, non-multiplexed processor bus and a large internal register array. The array is organised as pages of sixteen registers. Access takes two steps. A write whose top address bit is clear loads a persistent page register with the data byte. Any access whose top address bit is set then reaches one of sixteen registers in the selected page, using the low four address bits as the index. The page stays selected until software writes a new one, so repeated accesses within one page need no extra page write.

A static mode pin selects the style of bus strobe. Read and write strobes act separately in one style. In the other style a single data strobe is qualified by a read/write level. The active strobe is synchronised into the internal clock. Address and data are captured while the synchronised strobe is held, and a write is committed on the deasserting edge of that strobe. The block drives the page, index, write data and a one-cycle write enable toward the register array, and returns read data from the array or from the page register. Pages outside the valid range, and pages marked read-only, never receive a write enable.

Top module: `pgacc_top`

## Requirements
- R1: After reset the page register holds 01h, no array write enable is issued and the read data output is 00h.
- R2: A completed write with address bit 4 = 0 loads the data byte into the page register, whatever address bits 3..0 hold, and issues no array write enable.
- R3: A read with address bit 4 = 0 returns the current page number on the read data output.
- R4: A completed write with address bit 4 = 1 to a page in 01h..12h that is not read-only issues exactly one array write enable, carrying the current page, index = address bits 3..0 and the data byte.
- R5: A read with address bit 4 = 1 to a page in 01h..12h returns the array data addressed by the current page and by address bits 3..0.
- R6: The page register changes only on a completed write with address bit 4 = 0. It holds its value across any number of accesses with address bit 4 = 1.
- R7: Writes to a read-only page issue no array write enable. By default pages 02h, 04h, 06h, 0Bh, 0Eh and 0Fh are read-only (bit p of the read-only mask set).
- R8: A page number outside 01h..12h is accepted into the page register. Reads with address bit 4 = 1 then return 00h, and writes issue no array write enable.
- R9: With the mode pin high, reads use rd_n and writes use wr_n, and ds_n/rw are ignored. With the mode pin low, ds_n low with rw = 1 is a read and with rw = 0 is a write, and rd_n/wr_n are ignored.
- R10: An array write enable lasts one clock cycle. It is issued only after the synchronised write strobe has deasserted, never while the strobe is still held.
- R11: Strobes with cs_n high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_intel | input | 1 | 1: separate read/write strobes, 0: data strobe with read/write level |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe (mode_intel = 1) |
| wr_n | input | 1 | Active-low write strobe (mode_intel = 1) |
| ds_n | input | 1 | Active-low data strobe (mode_intel = 0) |
| rw | input | 1 | 1 = read, 0 = write (mode_intel = 0) |
| addr | input | 5 | Bus address; bit 4 picks page register or page window |
| din | input | 8 | Bus write data |
| dout | output | 8 | Bus read data |
| dout_oe | output | 1 | High while a qualified read strobe is asserted |
| rf_page | output | 8 | Page presented to the register array |
| rf_index | output | 4 | Register index within the page |
| rf_wdata | output | 8 | Write data toward the array |
| rf_we | output | 1 | One-cycle array write enable |
| rf_rdata | input | 8 | Read data from the array at rf_page/rf_index |

## Verification
The hardest case to reach is a write that must leave no trace: a write to a read-only page, to an out-of-range page, with chip select off, or with a strobe from the unselected style. The bench stands in for the register array. It counts every write enable and keeps a memory that any stray write would corrupt. A full sweep over page numbers 00h..14h and all sixteen indices, in both strobe styles, compares the enable count and the read-back against values computed from the page range and the read-only mask.

// File: rtl/pgacc_pkg.sv
package pgacc_pkg;
  localparam int ADDR_W = 5;
  localparam int IDX_W  = ADDR_W - 1;
  localparam int DATA_W = 8;
  localparam int MASK_W = 32;

  typedef struct packed {
    logic              win;   // address bit 4: page window access
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } bus_cap_t;

  function automatic logic page_in_range(input logic [DATA_W-1:0] p,
                                         input logic [DATA_W-1:0] lo,
                                         input logic [DATA_W-1:0] hi);
    return (p >= lo) && (p <= hi);
  endfunction

  function automatic logic page_read_only(input logic [DATA_W-1:0] p,
                                          input logic [MASK_W-1:0] mask);
    logic ro;
    ro = 1'b0;
    for (int k = 0; k < MASK_W; k++)
      if (p == DATA_W'(k)) ro = mask[k];
    return ro;
  endfunction

  function automatic logic [DATA_W-1:0] read_select(input logic win,
                                                    input logic in_range,
                                                    input logic [DATA_W-1:0] page,
                                                    input logic [DATA_W-1:0] arr);
    if (!win)     return page;
    if (in_range) return arr;
    return '0;
  endfunction
endpackage

// File: rtl/pgacc_strobe.sv
module pgacc_strobe #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_intel,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic ds_n,
  input  logic rw,
  output logic rd_raw,
  output logic wr_sync,
  output logic rd_sync,
  output logic wr_fall
);
  logic wr_raw;
  logic [SYNC_STAGES-1:0] wr_pipe, rd_pipe;
  logic wr_prev;

  always_comb begin
    if (mode_intel) begin
      wr_raw = !cs_n && !wr_n;
      rd_raw = !cs_n && !rd_n && wr_n;
    end else begin
      wr_raw = !cs_n && !ds_n && !rw;
      rd_raw = !cs_n && !ds_n && rw;
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          wr_pipe <= '0;
          rd_pipe <= '0;
        end else begin
          wr_pipe <= wr_raw;
          rd_pipe <= rd_raw;
        end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          wr_pipe <= '0;
          rd_pipe <= '0;
        end else begin
          wr_pipe <= {wr_pipe[SYNC_STAGES-2:0], wr_raw};
          rd_pipe <= {rd_pipe[SYNC_STAGES-2:0], rd_raw};
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wr_prev <= 1'b0;
    else        wr_prev <= wr_sync;

  assign wr_sync = wr_pipe[SYNC_STAGES-1];
  assign rd_sync = rd_pipe[SYNC_STAGES-1];
  assign wr_fall = wr_prev && !wr_sync;
endmodule

// File: rtl/pgacc_capture.sv
module pgacc_capture
  import pgacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output bus_cap_t          cap
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cap <= '0;
    else if (en) begin
      cap.win  <= addr[ADDR_W-1];
      cap.idx  <= addr[IDX_W-1:0];
      cap.data <= din;
    end
endmodule

// File: rtl/pgacc_page.sv
module pgacc_page
  import pgacc_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_PAGE = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] value,
  output logic [DATA_W-1:0] page_q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    page_q <= RESET_PAGE;
    else if (load) page_q <= value;
endmodule

// File: rtl/pgacc_top.sv
module pgacc_top
  import pgacc_pkg::*;
#(
  parameter int                PAGE_FIRST  = 1,
  parameter int                PAGE_LAST   = 18,
  parameter logic [DATA_W-1:0] RESET_PAGE  = 8'h01,
  parameter logic [MASK_W-1:0] RO_MASK     = 32'h0000_C854,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_intel,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              ds_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic [DATA_W-1:0] rf_page,
  output logic [IDX_W-1:0]  rf_index,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_we,
  input  logic [DATA_W-1:0] rf_rdata
);
  localparam logic [DATA_W-1:0] LO = DATA_W'(PAGE_FIRST);
  localparam logic [DATA_W-1:0] HI = DATA_W'(PAGE_LAST);

  logic     rd_raw, wr_sync, rd_sync, wr_fall;
  bus_cap_t cap;
  logic [DATA_W-1:0] page_q, rdata_q;
  logic     page_ok, page_ro, page_load, win_write;

  pgacc_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_strobe (
    .clk(clk), .rst_n(rst_n), .mode_intel(mode_intel), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .ds_n(ds_n), .rw(rw),
    .rd_raw(rd_raw), .wr_sync(wr_sync), .rd_sync(rd_sync), .wr_fall(wr_fall)
  );

  pgacc_capture u_capture (
    .clk(clk), .rst_n(rst_n), .en(wr_sync || rd_sync),
    .addr(addr), .din(din), .cap(cap)
  );

  assign page_load = wr_fall && !cap.win;

  pgacc_page #(.RESET_PAGE(RESET_PAGE)) u_page (
    .clk(clk), .rst_n(rst_n), .load(page_load), .value(cap.data), .page_q(page_q)
  );

  assign page_ok   = page_in_range(page_q, LO, HI);
  assign page_ro   = page_read_only(page_q, RO_MASK);
  assign win_write = wr_fall && cap.win;

  assign rf_page  = page_q;
  assign rf_index = cap.idx;
  assign rf_wdata = cap.data;
  assign rf_we    = win_write && page_ok && !page_ro;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       rdata_q <= '0;
    else if (rd_sync) rdata_q <= read_select(cap.win, page_ok, page_q, rf_rdata);

  assign dout    = rdata_q;
  assign dout_oe = rd_raw;
endmodule

// File: rtl/pgacc_checker.sv
module pgacc_checker #(
  parameter int          PAGE_FIRST = 1,
  parameter int          PAGE_LAST  = 18,
  parameter logic [31:0] RO_MASK    = 32'h0000_C854
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rf_we,
  input logic [7:0] rf_page,
  input logic       wr_sync,
  input logic       rd_sync,
  input logic       page_load,
  input logic       cap_win,
  input logic [7:0] cap_data,
  input logic [7:0] page_q,
  input logic [7:0] dout
);
  logic in_rng, ro_hit;
  assign in_rng = (int'(rf_page) >= PAGE_FIRST) && (int'(rf_page) <= PAGE_LAST);
  assign ro_hit = (rf_page < 8'd32) && RO_MASK[rf_page[4:0]];

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);  // R10
  AST_WE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (!wr_sync && $past(wr_sync)));  // R10
  AST_WE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> in_rng);  // R8
  AST_WE_NOT_RO: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !ro_hit);  // R7
  AST_PAGE_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    page_load |=> (page_q == $past(cap_data)));  // R2
  AST_PAGE_LOAD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    page_load |-> !rf_we);  // R2
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !page_load |=> $stable(page_q));  // R6
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sync && cap_win && !in_rng) |=> (dout == 8'h00));  // R8
endmodule

bind pgacc_top pgacc_checker #(
  .PAGE_FIRST(PAGE_FIRST), .PAGE_LAST(PAGE_LAST), .RO_MASK(RO_MASK)
) u_pgacc_checker (
  .clk(clk), .rst_n(rst_n), .rf_we(rf_we), .rf_page(rf_page),
  .wr_sync(wr_sync), .rd_sync(rd_sync), .page_load(page_load),
  .cap_win(cap.win), .cap_data(cap.data), .page_q(page_q), .dout(dout)
);

// File: tb/test_pgacc_top.sv
module test_pgacc_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_intel = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ds_n = 1'b1, rw = 1'b1;
  logic [4:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout, rf_page, rf_wdata, rf_rdata;
  logic [3:0] rf_index;
  logic dout_oe, rf_we;

  int vectors = 0;
  int fails = 0;
  int we_cnt = 0;
  bit done = 1'b0;

  logic [7:0] mem [0:18][0:15];

  always #2 clk = ~clk;

  pgacc_top i_pgacc_top (
    .clk(clk), .rst_n(rst_n), .mode_intel(mode_intel), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .ds_n(ds_n), .rw(rw), .addr(addr), .din(din),
    .dout(dout), .dout_oe(dout_oe), .rf_page(rf_page), .rf_index(rf_index),
    .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_rdata(rf_rdata)
  );

  function automatic logic [7:0] init_val(int p, int i);
    return 8'((p * 16 + i) ^ 8'h5A);
  endfunction

  function automatic bit valid_page(int p);
    return (p >= 1) && (p <= 18);
  endfunction

  function automatic bit ro_page(int p);
    return (p == 2) || (p == 4) || (p == 6) || (p == 11) || (p == 14) || (p == 15);
  endfunction

  // register array model
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 19; p++)
        for (int i = 0; i < 16; i++) mem[p][i] <= init_val(p, i);
    end else if (rf_we) begin
      we_cnt <= we_cnt + 1;
      if (rf_page <= 8'd18) mem[rf_page][rf_index] <= rf_wdata;
    end
  end
  assign rf_rdata = (rf_page <= 8'd18) ? mem[rf_page][rf_index] : 8'hEE;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [4:0] a, input logic [7:0] d,
                        output logic [7:0] q);
    @(posedge clk); #1;
    addr = a; din = d; cs_n = 1'b0;
    if (!mode_intel) rw = !wr;
    @(posedge clk); #1;
    if (mode_intel) begin
      if (wr) wr_n = 1'b0; else rd_n = 1'b0;
    end else ds_n = 1'b0;
    repeat (6) @(posedge clk);
    #1 q = dout;
    rd_n = 1'b1; wr_n = 1'b1; ds_n = 1'b1;
    @(posedge clk); #1;
    cs_n = 1'b1; rw = 1'b1;
    repeat (6) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] q, d, exp;
    int base;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    // R1: reset state
    chk(dout == 8'h00, "R1 dout", dout, 0);
    chk(we_cnt == 0, "R1 we", we_cnt, 0);
    access(1'b0, 5'h00, 8'h00, q);
    chk(q == 8'h01, "R1 page", q, 1);

    for (int m = 1; m >= 0; m--) begin
      mode_intel = m[0];
      for (int p = 0; p <= 20; p++) begin
        // R2: low address bits are ignored for the page write
        base = we_cnt;
        access(1'b1, {1'b0, 4'(p) ^ 4'hA}, 8'(p), q);
        chk(we_cnt == base, "R2 no we", we_cnt - base, 0);
        access(1'b0, {1'b0, 4'(p * 3)}, 8'h00, q);
        chk(q == 8'(p), "R3 page read", q, p);
        for (int i = 0; i < 16; i++) begin
          d = 8'((p * 7 + i * 13 + m * 8'h41) ^ 8'hC3);
          base = we_cnt;
          access(1'b1, {1'b1, 4'(i)}, d, q);
          if (valid_page(p) && !ro_page(p))
            chk(we_cnt == base + 1, "R4 one we", we_cnt - base, 1);
          else if (!valid_page(p))
            chk(we_cnt == base, "R8 no we", we_cnt - base, 0);
          else
            chk(we_cnt == base, "R7 no we", we_cnt - base, 0);
          access(1'b0, {1'b1, 4'(i)}, 8'h00, q);
          if (!valid_page(p)) exp = 8'h00;
          else if (ro_page(p)) exp = init_val(p, i);
          else exp = d;
          if (valid_page(p)) chk(q == exp, "R5 read", q, exp);
          else chk(q == exp, "R8 read zero", q, exp);
        end
        // R6: page survives sixteen window accesses
        access(1'b0, 5'h00, 8'h00, q);
        chk(q == 8'(p), "R6 page held", q, p);
      end
    end

    // R9: strobes of the other style are ignored
    mode_intel = 1'b1;
    access(1'b1, 5'h00, 8'h03, q);
    base = we_cnt;
    @(posedge clk); #1;
    addr = 5'h12; din = 8'hA7; cs_n = 1'b0; rw = 1'b0;
    @(posedge clk); #1 ds_n = 1'b0;
    repeat (6) @(posedge clk);
    #1 ds_n = 1'b1; rw = 1'b1; cs_n = 1'b1;
    repeat (6) @(posedge clk);
    #1 chk(we_cnt == base, "R9 ds ignored in intel", we_cnt - base, 0);
    mode_intel = 1'b0;
    @(posedge clk); #1;
    addr = 5'h12; din = 8'hA8; cs_n = 1'b0;
    @(posedge clk); #1 wr_n = 1'b0;
    repeat (6) @(posedge clk);
    #1 wr_n = 1'b1; cs_n = 1'b1;
    repeat (6) @(posedge clk);
    #1 chk(we_cnt == base, "R9 wr_n ignored in motorola", we_cnt - base, 0);
    access(1'b0, 5'h12, 8'h00, q);
    chk(q == 8'(((3 * 7 + 2 * 13) ^ 8'hC3)), "R9 data kept", q, ((3 * 7 + 2 * 13) ^ 8'hC3));

    // R11: chip select off
    mode_intel = 1'b1;
    @(posedge clk); #1;
    addr = 5'h00; din = 8'h09; cs_n = 1'b1;
    @(posedge clk); #1 wr_n = 1'b0;
    repeat (6) @(posedge clk);
    #1 wr_n = 1'b1;
    repeat (6) @(posedge clk);
    access(1'b0, 5'h00, 8'h00, q);
    chk(q == 8'h03, "R11 page unchanged", q, 3);

    // R10: no enable while the strobe is still held
    base = we_cnt;
    @(posedge clk); #1;
    addr = 5'h15; din = 8'h77; cs_n = 1'b0;
    @(posedge clk); #1 wr_n = 1'b0;
    repeat (10) @(posedge clk);
    #1 chk(we_cnt == base, "R10 held strobe", we_cnt - base, 0);
    wr_n = 1'b1;
    @(posedge clk); #1 cs_n = 1'b1;
    repeat (6) @(posedge clk);
    #1 chk(we_cnt == base + 1, "R10 after release", we_cnt - base, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule